// File: doc/BRIEF.md
# Processor Idle-State Sequencer

This block sits inside a platform power-management controller and walks a host processor between the idle levels C0 to C4. A requester presents the wanted level on `req_lvl`; a wake or break event on `wake` brings the processor back to C0. The block drives four active-level controls toward the processor, the clock generator and the core regulator: a stop-clock request, a deep-sleep line, a processor-clock-off line and a low-core-voltage select. It also drives a flag that keeps bus-master memory traffic out while the processor clocks are being stopped.

Every deeper level adds one more control step on top of the shallower one, and each step is spaced by a fixed number of cycles. Leaving a level undoes the steps in reverse order. Before any clock is restarted, the exit from C4 waits for the regulator to report good or for a timeout. A wake that arrives part-way through an entry undoes only the steps already taken. While the processor runs in C0, the stop-clock request can be duty-cycled to throttle it.

The requester must drop `req_lvl` back to 0 before it signals `wake`. A level request is only taken while the block is fully back in C0.

Top module: `cstate_seq`

## Requirements
- R1: After reset `halt_req_n`, `sleep_n` and `clkoff_n` are 1, and `vcore_lo` and `mem_block` are 0.
- R2: In C0 with `thr_en`=1 and duty value N on `thr_duty`, `halt_req_n` is 0 in exactly N of any 8 consecutive cycles. N=0 or `thr_en`=0 keeps it at 1.
- R3: `req_lvl`=1 (C1) asserts none of the four controls, even with throttling enabled, until `wake`. After the wake, throttling resumes.
- R4: `req_lvl`=2 (C2) pulls `halt_req_n` low at the first clock edge that samples the request. While the block stays in C2, `sleep_n`, `clkoff_n`, `vcore_lo` and `mem_block` stay inactive.
- R5: For `req_lvl`=3 (C3), `sleep_n` falls at the first edge that is at least STEP_DLY cycles after `halt_req_n` fell and at which `grant_ack` has been seen. `clkoff_n` falls STEP_DLY cycles after `sleep_n`.
- R6: `mem_block` is 1 exactly while `sleep_n` is 0.
- R7: For `req_lvl`>=4 (C4), the C3 sequence runs first. `vcore_lo` then rises STEP_DLY cycles after `clkoff_n` fell.
- R8: On `wake`, the controls are released in the order `clkoff_n`, `sleep_n`, `halt_req_n`. The first release comes STEP_DLY edges after the edge that samples `wake`, and each later release comes STEP_DLY cycles after the one before.
- R9: On `wake` from C4, `vcore_lo` falls first, STEP_DLY edges after the wake edge. `clkoff_n` stays 0 until the edge that samples `vreg_ok`=1, or at most VR_TMO cycles after `vcore_lo` fell.
- R10: A `wake` during an entry sequence releases only the controls already asserted, in reverse order, and asserts no further control.
- R11: A `wake` while in C0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lvl | input | 3 | Requested idle level: 0 none, 1 C1, 2 C2, 3 C3, 4 to 7 C4 |
| wake | input | 1 | Wake or break event, one cycle is enough |
| grant_ack | input | 1 | Stop-grant acknowledge from the processor |
| vreg_ok | input | 1 | Core regulator reports normal voltage reached |
| thr_en | input | 1 | Enable throttling in C0 |
| thr_duty | input | DUTY_W | Number of slots out of 2**DUTY_W with the stop-clock request asserted |
| halt_req_n | output | 1 | Stop-clock request to the processor, active low |
| sleep_n | output | 1 | Deep-sleep line, active low |
| clkoff_n | output | 1 | Stop-processor-clock line to the clock generator, active low |
| vcore_lo | output | 1 | Selects the lower core voltage |
| mem_block | output | 1 | Blocks bus-master memory traffic |

## Verification
The bench builds the block with its default values: STEP_DLY=4, VR_TMO=64 and DUTY_W=3. With a step spacing of 4, an entry step can be held back by a late acknowledge and still be told apart from a step that is only waiting on spacing. It also leaves room to land a wake between the deep-sleep and clock-off steps. A 64-cycle voltage timeout is short enough to wait out in full, so both the regulator-good path and the timeout path of the C4 exit are reached, and the three-bit duty covers the zero, middle and near-full throttle settings.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
// cseq_pkg: shared depth encoding for the idle-state sequencer.
// Depth counts how many control steps are currently applied; each
// deeper level adds exactly one step, so outputs decode from depth.
package cseq_pkg;

    typedef logic [2:0] depth_t;

    localparam depth_t D_NONE = 3'd0;  // nothing asserted
    localparam depth_t D_STOP = 3'd1;  // stop-clock request
    localparam depth_t D_SLP  = 3'd2;  // plus deep sleep
    localparam depth_t D_CLK  = 3'd3;  // plus clock off
    localparam depth_t D_VLOW = 3'd4;  // plus low core voltage

    localparam logic [2:0] LVL_HALT = 3'd1;

    // Map a requested idle level to the step depth it needs.
    function automatic depth_t depth_for_level(input logic [2:0] lvl);
        case (lvl)
            3'd0, 3'd1: return D_NONE;
            3'd2:       return D_STOP;
            3'd3:       return D_CLK;
            default:    return D_VLOW;
        endcase
    endfunction

endpackage

// File: rtl/cseq_timer.sv
`timescale 1ns/1ps
// cseq_timer: saturating cycle counter measuring time since last clear.
// Assumes the caller clears it on every sequencer step.
module cseq_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    // Count up from zero after a clear, hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cseq_throttle.sv
`timescale 1ns/1ps
// cseq_throttle: duty-cycle generator for the stop-clock request in C0.
// Asserts its request in `duty` of every 2**DUTY_W cycles while `run`
// and `en` are high; the slot counter restarts when either drops.
module cseq_throttle #(
    parameter int DUTY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    output logic              thr_req
);
    logic [DUTY_W-1:0] slot_q;

    // Walk the slot counter around the period while throttling.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !en) slot_q <= '0;
        else                       slot_q <= slot_q + 1'b1;
    end

    // Register the request for the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_req <= 1'b0;
        else        thr_req <= run && en && (slot_q < duty);
    end
endmodule

// File: rtl/cseq_ladder.sv
`timescale 1ns/1ps
// cseq_ladder: step controller. Holds the current step depth and
// moves it one step at a time toward the requested target or, after
// a wake, back toward zero. Assumes `cnt` is the timer that it clears
// through `clr` whenever it steps or begins to unwind.
module cseq_ladder
    import cseq_pkg::*;
#(
    parameter int STEP_DLY = 4,
    parameter int VR_TMO   = 64,
    parameter int CW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    req_lvl,
    input  logic          wake,
    input  logic          grant_ack,
    input  logic          vreg_ok,
    input  logic [CW-1:0] cnt,
    output logic          clr,
    output logic          run,
    output depth_t        depth
);
    localparam logic [CW-1:0] GAP_LAST = CW'(STEP_DLY - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(VR_TMO - 1);

    depth_t depth_q, depth_d, tgt_q, tgt_d, lvl_depth;
    logic   unwind_q, unwind_d, halt_q, halt_d;
    logic   vwait_q, vwait_d, ack_q, ack_d;
    logic   idle, gap_ok, volt_ok;

    assign lvl_depth = depth_for_level(req_lvl);
    assign idle      = (depth_q == D_NONE) && !unwind_q && !halt_q;
    assign gap_ok    = cnt >= GAP_LAST;
    assign volt_ok   = vreg_ok || (cnt >= TMO_LAST);
    assign run       = idle;
    assign depth     = depth_q;

    // Decide the next step, halt entry/exit and unwinding.
    always_comb begin
        depth_d  = depth_q;
        tgt_d    = tgt_q;
        unwind_d = unwind_q;
        halt_d   = halt_q;
        vwait_d  = vwait_q;
        ack_d    = ack_q;
        clr      = 1'b0;
        if (depth_q == D_NONE) ack_d = 1'b0;
        else if (grant_ack)    ack_d = 1'b1;
        if (halt_q) begin
            if (wake) halt_d = 1'b0;
        end else if (idle) begin
            if (!wake) begin
                if (lvl_depth != D_NONE) begin
                    depth_d = D_STOP;
                    tgt_d   = lvl_depth;
                    clr     = 1'b1;
                end else if (req_lvl == LVL_HALT) begin
                    halt_d = 1'b1;
                end
            end
        end else if (unwind_q) begin
            if (vwait_q ? volt_ok : gap_ok) begin
                depth_d = depth_q - 1'b1;
                clr     = 1'b1;
                vwait_d = (depth_q == D_VLOW);
                if (depth_q == D_STOP) unwind_d = 1'b0;
            end
        end else if (wake) begin
            unwind_d = 1'b1;
            clr      = 1'b1;
        end else if ((depth_q < tgt_q) && gap_ok &&
                     ((depth_q != D_STOP) || ack_q || grant_ack)) begin
            depth_d = depth_q + 1'b1;
            clr     = 1'b1;
        end
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q  <= D_NONE;
            tgt_q    <= D_NONE;
            unwind_q <= 1'b0;
            halt_q   <= 1'b0;
            vwait_q  <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            depth_q  <= depth_d;
            tgt_q    <= tgt_d;
            unwind_q <= unwind_d;
            halt_q   <= halt_d;
            vwait_q  <= vwait_d;
            ack_q    <= ack_d;
        end
    end
endmodule

// File: rtl/cstate_seq.sv
`timescale 1ns/1ps
// cstate_seq: processor idle-state sequencer (C0..C4) with C0 throttling.
// Assumes the requester drops req_lvl before signalling wake, and that
// grant_ack and vreg_ok are synchronous to clk.
module cstate_seq
    import cseq_pkg::*;
#(
    parameter int STEP_DLY = 4,
    parameter int VR_TMO   = 64,
    parameter int DUTY_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_lvl,
    input  logic              wake,
    input  logic              grant_ack,
    input  logic              vreg_ok,
    input  logic              thr_en,
    input  logic [DUTY_W-1:0] thr_duty,
    output logic              halt_req_n,
    output logic              sleep_n,
    output logic              clkoff_n,
    output logic              vcore_lo,
    output logic              mem_block
);
    localparam int MAXW = (STEP_DLY > VR_TMO) ? STEP_DLY : VR_TMO;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;
    logic          clr, run, thr_req;
    depth_t        depth;

    cseq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt)
    );

    cseq_ladder #(.STEP_DLY(STEP_DLY), .VR_TMO(VR_TMO), .CW(CW)) u_ladder (
        .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .wake(wake),
        .grant_ack(grant_ack), .vreg_ok(vreg_ok), .cnt(cnt),
        .clr(clr), .run(run), .depth(depth)
    );

    cseq_throttle #(.DUTY_W(DUTY_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .run(run), .en(thr_en),
        .duty(thr_duty), .thr_req(thr_req)
    );

    // Decode the step depth into the platform controls.
    always_comb begin
        halt_req_n = !((depth >= D_STOP) || thr_req);
        sleep_n    = !(depth >= D_SLP);
        clkoff_n   = !(depth >= D_CLK);
        vcore_lo   = (depth == D_VLOW);
        mem_block  = (depth >= D_SLP);
    end
endmodule

// File: rtl/cstate_seq_chk.sv
`timescale 1ns/1ps
// cstate_seq_chk: protocol checker for cstate_seq, bound to every instance.
// Watches only the ports; keeps one flag recording a grant seen while
// the stop-clock request is low.
module cstate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_ack,
    input logic halt_req_n,
    input logic sleep_n,
    input logic clkoff_n,
    input logic vcore_lo,
    input logic mem_block
);
    logic past_rst_q;
    logic grant_seen_q;

    // Remember whether the previous edge was in reset.
    always_ff @(posedge clk) past_rst_q <= !rst_n;

    // Track a stop-grant acknowledge during the current stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_seen_q <= 1'b0;
        else        grant_seen_q <= !halt_req_n && (grant_ack || grant_seen_q);
    end

    // R1: outputs idle on the cycle after a reset edge.
    always_ff @(posedge clk) begin
        if (past_rst_q) begin
            a_r1_idle_after_reset: assert (halt_req_n && sleep_n && clkoff_n &&
                                           !vcore_lo && !mem_block)
                else $error("R1 outputs not idle after reset");
        end
    end

    a_r5_sleep_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |-> !halt_req_n);
    a_r5_clkoff_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !clkoff_n |-> !sleep_n);
    a_r5_sleep_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_n) |-> grant_seen_q);
    a_r6_block_with_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        mem_block == !sleep_n);
    a_r7_vlow_needs_clkoff: assert property (@(posedge clk) disable iff (!rst_n)
        vcore_lo |-> !clkoff_n);
    a_r9_volt_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkoff_n) |-> !$past(vcore_lo));
endmodule

bind cstate_seq cstate_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .grant_ack(grant_ack),
    .halt_req_n(halt_req_n), .sleep_n(sleep_n), .clkoff_n(clkoff_n),
    .vcore_lo(vcore_lo), .mem_block(mem_block)
);

// File: tb/sim_cstate_seq.sv
`timescale 1ns/1ps
// sim_cstate_seq: directed bench, one task per scenario.
module sim_cstate_seq;
    localparam int DLY = 4;
    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_lvl = '0;
    logic       wake = 1'b0, grant_ack = 1'b0, vreg_ok = 1'b0, thr_en = 1'b0;
    logic [2:0] thr_duty = '0;
    logic       halt_req_n, sleep_n, clkoff_n, vcore_lo, mem_block;

    int total = 0, bad = 0, ncyc = 0;
    bit done = 0;
    int ts_hr_fall, ts_hr_rise, ts_sl_fall, ts_sl_rise, ts_co_fall, ts_co_rise;
    int ts_vl_rise, ts_vl_fall, ts_wake, n_co_fall = 0, n_vl_rise = 0;
    logic p_hr = 1, p_sl = 1, p_co = 1, p_vl = 0;

    always #2 clk = ~clk;

    cstate_seq #(.STEP_DLY(DLY), .VR_TMO(TMO), .DUTY_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .wake(wake),
        .grant_ack(grant_ack), .vreg_ok(vreg_ok), .thr_en(thr_en),
        .thr_duty(thr_duty), .halt_req_n(halt_req_n), .sleep_n(sleep_n),
        .clkoff_n(clkoff_n), .vcore_lo(vcore_lo), .mem_block(mem_block)
    );

    // Timestamp output changes at the falling edge.
    always @(negedge clk) begin
        ncyc++;
        if (p_hr && !halt_req_n) ts_hr_fall = ncyc;
        if (!p_hr && halt_req_n) ts_hr_rise = ncyc;
        if (p_sl && !sleep_n)    ts_sl_fall = ncyc;
        if (!p_sl && sleep_n)    ts_sl_rise = ncyc;
        if (p_co && !clkoff_n) begin ts_co_fall = ncyc; n_co_fall++; end
        if (!p_co && clkoff_n)   ts_co_rise = ncyc;
        if (!p_vl && vcore_lo) begin ts_vl_rise = ncyc; n_vl_rise++; end
        if (p_vl && !vcore_lo)   ts_vl_fall = ncyc;
        p_hr = halt_req_n; p_sl = sleep_n; p_co = clkoff_n; p_vl = vcore_lo;
    end

    // Timestamp the cycle whose edge samples wake.
    always @(posedge clk) if (wake) ts_wake = ncyc;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return halt_req_n;
            1: return sleep_n;
            2: return clkoff_n;
            default: return vcore_lo;
        endcase
    endfunction

    task automatic wait_until(input int sel, input logic val, input int limit);
        int n = 0;
        @(negedge clk);
        while (pick(sel) !== val && n < limit) begin
            @(negedge clk);
            n++;
        end
        #1;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!halt_req_n) n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(halt_req_n && sleep_n && clkoff_n && !vcore_lo && !mem_block,
            "R1 idle after reset", {halt_req_n, sleep_n, clkoff_n, vcore_lo, mem_block}, 5'b11100);
    endtask

    task automatic t_throttle(input logic [2:0] duty);
        int n;
        @(negedge clk) begin thr_en = 1'b1; thr_duty = duty; end
        repeat (4) @(negedge clk);
        count_low(n);
        chk(n == int'(duty), "R2 throttle low slots", n, int'(duty));
        @(negedge clk) thr_en = 1'b0;
        repeat (3) @(negedge clk);
        count_low(n);
        chk(n == 0, "R2 throttle off", n, 0);
    endtask

    task automatic t_c1();
        int n = 0;
        @(negedge clk) begin thr_en = 1'b1; thr_duty = 3'd5; req_lvl = 3'd1; end
        @(negedge clk) req_lvl = 3'd0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!halt_req_n || !sleep_n || !clkoff_n || vcore_lo) n++;
        end
        chk(n == 0, "R3 C1 drives nothing", n, 0);
        pulse_wake();
        repeat (4) @(negedge clk);
        count_low(n);
        chk(n == 5, "R3 throttle resumes after C1", n, 5);
        @(negedge clk) thr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_c2();
        @(negedge clk) req_lvl = 3'd2;
        @(negedge clk) grant_ack = 1'b1;
        chk(!halt_req_n, "R4 stop request on C2 entry", halt_req_n, 0);
        repeat (12) @(negedge clk);
        chk(sleep_n && clkoff_n && !vcore_lo && !mem_block, "R4 C2 only stop request",
            {sleep_n, clkoff_n, vcore_lo, mem_block}, 4'b1100);
        req_lvl = 3'd0;
        pulse_wake();
        wait_until(0, 1'b1, 40);
        chk(ts_hr_rise - ts_wake == DLY + 1, "R8 C2 release delay", ts_hr_rise - ts_wake, DLY + 1);
        grant_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_c3_late_grant();
        @(negedge clk) req_lvl = 3'd3;
        repeat (20) @(negedge clk);
        chk(sleep_n, "R5 no deep sleep before grant", sleep_n, 1);
        grant_ack = 1'b1;
        @(negedge clk);
        chk(!sleep_n, "R5 deep sleep at grant edge", sleep_n, 0);
        chk(mem_block, "R6 memory blocked in deep sleep", mem_block, 1);
        wait_until(2, 1'b0, 40);
        chk(ts_co_fall - ts_sl_fall == DLY, "R5 clock-off spacing", ts_co_fall - ts_sl_fall, DLY);
        req_lvl = 3'd0;
        pulse_wake();
        wait_until(0, 1'b1, 60);
        chk(ts_co_rise - ts_wake == DLY + 1, "R8 first release", ts_co_rise - ts_wake, DLY + 1);
        chk(ts_sl_rise - ts_co_rise == DLY, "R8 deep-sleep release", ts_sl_rise - ts_co_rise, DLY);
        chk(ts_hr_rise - ts_sl_rise == DLY, "R8 stop release", ts_hr_rise - ts_sl_rise, DLY);
        chk(!mem_block, "R6 memory unblocked in C0", mem_block, 0);
        grant_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_c4(input logic [2:0] lvl, input bit use_vreg);
        @(negedge clk) begin req_lvl = lvl; grant_ack = 1'b1; vreg_ok = 1'b0; end
        wait_until(3, 1'b1, 80);
        chk(ts_sl_fall - ts_hr_fall == DLY, "R5 deep-sleep spacing", ts_sl_fall - ts_hr_fall, DLY);
        chk(ts_co_fall - ts_sl_fall == DLY, "R5 clock-off spacing C4", ts_co_fall - ts_sl_fall, DLY);
        chk(ts_vl_rise - ts_co_fall == DLY, "R7 low voltage spacing", ts_vl_rise - ts_co_fall, DLY);
        req_lvl = 3'd0;
        repeat (5) @(negedge clk);
        pulse_wake();
        wait_until(3, 1'b0, 40);
        chk(ts_vl_fall - ts_wake == DLY + 1, "R9 voltage restore first", ts_vl_fall - ts_wake, DLY + 1);
        chk(!clkoff_n, "R9 clock held during restore", clkoff_n, 0);
        if (use_vreg) begin
            repeat (10) @(negedge clk);
            chk(!clkoff_n, "R9 clock held until regulator good", clkoff_n, 0);
            vreg_ok = 1'b1;
            @(negedge clk);
            chk(clkoff_n, "R9 clock released on regulator good", clkoff_n, 1);
        end else begin
            wait_until(2, 1'b1, 200);
            chk(ts_co_rise - ts_vl_fall == TMO, "R9 voltage timeout", ts_co_rise - ts_vl_fall, TMO);
        end
        wait_until(0, 1'b1, 60);
        chk(ts_sl_rise - ts_co_rise == DLY, "R8 C4 deep-sleep release", ts_sl_rise - ts_co_rise, DLY);
        chk(ts_hr_rise - ts_sl_rise == DLY, "R8 C4 stop release", ts_hr_rise - ts_sl_rise, DLY);
        vreg_ok = 1'b0;
        grant_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abort();
        int co0, vl0;
        co0 = n_co_fall;
        vl0 = n_vl_rise;
        @(negedge clk) begin req_lvl = 3'd4; grant_ack = 1'b1; end
        wait_until(1, 1'b0, 40);
        wake = 1'b1;
        req_lvl = 3'd0;
        @(negedge clk) wake = 1'b0;
        wait_until(0, 1'b1, 60);
        chk(ts_sl_rise - ts_wake == DLY + 1, "R10 unwind deep sleep", ts_sl_rise - ts_wake, DLY + 1);
        chk(ts_hr_rise - ts_sl_rise == DLY, "R10 unwind stop", ts_hr_rise - ts_sl_rise, DLY);
        chk(n_co_fall == co0 && n_vl_rise == vl0, "R10 no further entry step",
            n_co_fall - co0 + n_vl_rise - vl0, 0);
        grant_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_wake_idle();
        int n = 0;
        pulse_wake();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!halt_req_n || !sleep_n || !clkoff_n || vcore_lo || mem_block) n++;
        end
        chk(n == 0, "R11 wake in C0 ignored", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_throttle(3'd3);
        t_throttle(3'd7);
        t_throttle(3'd0);
        t_c1();
        t_c2();
        t_c3_late_grant();
        t_c4(3'd4, 1'b0);
        t_c4(3'd7, 1'b1);
        t_abort();
        t_wake_idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule